// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Matcher

This block sits after a CAN controller's receive framing logic. It decides which receive mailbox gets each completed frame. Every mailbox holds a 29-bit acceptance identifier, a 29-bit acceptance mask of its own, an enable bit and a full flag. When a frame-valid strobe arrives, the frame is captured. In the following cycle its extended identifier is compared against every enabled mailbox under that mailbox's mask.

Among the matching mailboxes that are still empty, the lowest-numbered one is chosen. It receives the identifier, length code and eight data bytes, its full flag is set and a store event is pulsed. Matching mailboxes that are full are passed over. A broad filter placed at a higher index therefore collects the frames that overflow from stricter, lower mailboxes, and several mailboxes that share one filter fill up in index order. A frame with no empty matching mailbox is dropped. It is reported either as an overrun on the highest-numbered matching mailbox or as a no-match event. Frames sent by this node are discarded.

Software configures the mailboxes, reads the stored frames and releases them through a flat register port. The full flags double as per-mailbox interrupt lines.

Top module: `can_rx_matcher`

## Requirements
- R1: A mailbox matches a 29-bit identifier when every identifier bit whose mask bit is 1 equals the mailbox's acceptance bit; bits whose mask bit is 0 are ignored (mask 0x1FFFFF00 accepts any low byte, mask 0 accepts every identifier).
- R2: A mailbox whose enable bit is 0 never matches, whatever its identifier and mask.
- R3: When several empty enabled mailboxes match, the frame is stored in the lowest-numbered one.
- R4: A matching mailbox whose full flag is set is skipped, and the frame goes to the next higher-numbered empty matching mailbox.
- R5: Successive frames accepted by a group of mailboxes sharing one filter fill that group in ascending index order while the earlier ones stay unread.
- R6: A frame with the own-transmit flag set is never stored and produces no event.
- R7: If no empty mailbox matches, no mailbox changes. If at least one enabled mailbox matches, evOverrun pulses with evIdx set to the highest-numbered matching mailbox. Otherwise evNoMatch pulses with evIdx 0.
- R8: For a strobe sampled at clock edge k, the destination's received identifier, length code and data, its full flag and the one-cycle evStore pulse with evIdx all become visible after edge k+1. Exactly one of evStore, evOverrun and evNoMatch pulses per accepted strobe.
- R9: A control-field write with bit 1 = 0 clears the full flag. A write at the same edge as a frame strobe already affects that frame's evaluation.
- R10: Register map: regAddr = {mailbox, field}; field 0 acceptance identifier, 1 mask, 2 control (bit 0 enable, bit 1 full), 3 received identifier, 4 length code, 5 data bytes 0..3, 6 data bytes 4..7 (byte 0 in bits 7:0, taken from frmData[7:0]). Reads are combinational. After reset every field reads 0.
- R11: A control write that lands on the same edge as a store into that mailbox updates the enable bit, but the full flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | One-cycle strobe: a received frame is complete |
| frmSelf | input | 1 | Frame was transmitted by this node |
| frmId | input | 29 | Extended identifier of the frame |
| frmDlc | input | 4 | Length code of the frame |
| frmData | input | 64 | Payload, byte 0 in bits 7:0 |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | IDX_W+3 | Host address {mailbox, field} |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for regAddr |
| mbFull | output | NUM_MBOX | Full flag per mailbox, used as interrupt lines |
| evStore | output | 1 | Frame stored in mailbox evIdx |
| evOverrun | output | 1 | Frame dropped, matching mailbox evIdx was full |
| evNoMatch | output | 1 | Frame dropped, no enabled mailbox matched |
| evIdx | output | IDX_W | Mailbox index for the event |

## Verification
The bench targets the overflow path: three mailboxes share a filter and a permissive mailbox sits above them. A design that ignored the full flag would overwrite the lowest mailbox, and one that searched from the top would send every frame to the catch-all. The bench also drives a drop with every match full and checks that the overrun reports the last matching index and leaves the stored contents untouched, which catches a design that writes anyway or reports the first match. It also lines up a host release with a frame strobe on the same edge, and a host write with a store on the same edge. These catch a clear that is applied one cycle late, and a host write that wins over the store.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W      = 29;
  localparam int DLC_W     = 4;
  localparam int DATA_W    = 64;
  localparam int REG_W     = 32;
  localparam int FLD_W     = 3;
  localparam int IDX_MAX_W = 8;

  typedef enum logic [FLD_W-1:0] {
    FLD_FILT_ID = 3'd0,
    FLD_MASK    = 3'd1,
    FLD_CTRL    = 3'd2,
    FLD_RX_ID   = 3'd3,
    FLD_DLC     = 3'd4,
    FLD_DATA_LO = 3'd5,
    FLD_DATA_HI = 3'd6
  } mbFieldE;

  // control -> datapath strobes
  typedef struct packed {
    logic                 store;
    logic [IDX_MAX_W-1:0] idx;
  } mbStrobeT;
endpackage

// File: rtl/can_rx_match_ctrl.sv
module can_rx_match_ctrl
  import can_rx_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  localparam int IDX_W = $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frmValid,
  input  logic                frmSelf,
  input  logic [ID_W-1:0]     frmId,
  input  logic [DLC_W-1:0]    frmDlc,
  input  logic [DATA_W-1:0]   frmData,
  input  logic [NUM_MBOX-1:0] hitVec,
  input  logic [NUM_MBOX-1:0] fullVec,
  output logic [ID_W-1:0]     pendId,
  output logic [DLC_W-1:0]    pendDlc,
  output logic [DATA_W-1:0]   pendData,
  output mbStrobeT            strobe,
  output logic                evStore,
  output logic                evOverrun,
  output logic                evNoMatch,
  output logic [IDX_W-1:0]    evIdx
);
  logic                 pendValid;
  logic [NUM_MBOX-1:0]  freeHit;
  logic [IDX_MAX_W-1:0] pickFree;
  logic                 anyFree;
  logic [IDX_W-1:0]     lastHit;
  logic                 anyHit;

  // capture stage: own-transmit frames never enter evaluation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendId    <= '0;
      pendDlc   <= '0;
      pendData  <= '0;
    end else begin
      pendValid <= frmValid & ~frmSelf;
      if (frmValid) begin
        pendId   <= frmId;
        pendDlc  <= frmDlc;
        pendData <= frmData;
      end
    end
  end

  // priority selection over the mailbox hit vector
  always_comb begin
    freeHit  = hitVec & ~fullVec;
    pickFree = '0;
    anyFree  = 1'b0;
    for (int i = NUM_MBOX - 1; i >= 0; i--) begin
      if (freeHit[i]) begin
        pickFree = IDX_MAX_W'(i);
        anyFree  = 1'b1;
      end
    end
    lastHit = '0;
    anyHit  = |hitVec;
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (hitVec[i]) lastHit = IDX_W'(i);
    end
  end

  always_comb begin
    strobe.store = pendValid & anyFree;
    strobe.idx   = pickFree;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evStore   <= 1'b0;
      evOverrun <= 1'b0;
      evNoMatch <= 1'b0;
      evIdx     <= '0;
    end else begin
      evStore   <= pendValid & anyFree;
      evOverrun <= pendValid & ~anyFree & anyHit;
      evNoMatch <= pendValid & ~anyHit;
      if (pendValid && anyFree)     evIdx <= pickFree[IDX_W-1:0];
      else if (pendValid && anyHit) evIdx <= lastHit;
      else                          evIdx <= '0;
    end
  end
endmodule

// File: rtl/can_rx_mbox_store.sv
module can_rx_mbox_store
  import can_rx_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  localparam int IDX_W  = $clog2(NUM_MBOX),
  localparam int ADDR_W = IDX_W + FLD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [ID_W-1:0]     pendId,
  input  logic [DLC_W-1:0]    pendDlc,
  input  logic [DATA_W-1:0]   pendData,
  input  mbStrobeT            strobe,
  output logic [NUM_MBOX-1:0] hitVec,
  output logic [NUM_MBOX-1:0] fullVec
);
  logic [IDX_W-1:0]  selMb;
  logic [FLD_W-1:0]  selFld;
  logic [ID_W-1:0]   filtArr [NUM_MBOX];
  logic [ID_W-1:0]   maskArr [NUM_MBOX];
  logic [ID_W-1:0]   rxIdArr [NUM_MBOX];
  logic [DLC_W-1:0]  dlcArr  [NUM_MBOX];
  logic [DATA_W-1:0] dataArr [NUM_MBOX];
  logic [NUM_MBOX-1:0] enVec;
  logic unusedWrHi;

  assign selMb      = regAddr[ADDR_W-1:FLD_W];
  assign selFld     = regAddr[FLD_W-1:0];
  assign unusedWrHi = ^regWrData[REG_W-1:ID_W];

  for (genvar g = 0; g < NUM_MBOX; g++) begin : gMbox
    logic [ID_W-1:0]   filtQ, maskQ, rxIdQ;
    logic [DLC_W-1:0]  dlcQ;
    logic [DATA_W-1:0] dataQ;
    logic              enQ, fullQ;
    logic              hostHit, storeHit;

    assign hostHit  = regWrEn && (selMb == IDX_W'(g));
    assign storeHit = strobe.store && (strobe.idx == IDX_MAX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        filtQ <= '0;
        maskQ <= '0;
        rxIdQ <= '0;
        dlcQ  <= '0;
        dataQ <= '0;
        enQ   <= 1'b0;
        fullQ <= 1'b0;
      end else begin
        if (hostHit) begin
          case (selFld)
            FLD_FILT_ID: filtQ <= regWrData[ID_W-1:0];
            FLD_MASK:    maskQ <= regWrData[ID_W-1:0];
            FLD_CTRL: begin
              enQ   <= regWrData[0];
              fullQ <= regWrData[1];
            end
            default: ;
          endcase
        end
        // a store on the same edge keeps the mailbox full
        if (storeHit) begin
          fullQ <= 1'b1;
          rxIdQ <= pendId;
          dlcQ  <= pendDlc;
          dataQ <= pendData;
        end
      end
    end

    assign hitVec[g]  = enQ && (((pendId ^ filtQ) & maskQ) == '0);
    assign fullVec[g] = fullQ;
    assign enVec[g]   = enQ;
    assign filtArr[g] = filtQ;
    assign maskArr[g] = maskQ;
    assign rxIdArr[g] = rxIdQ;
    assign dlcArr[g]  = dlcQ;
    assign dataArr[g] = dataQ;
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (selMb == IDX_W'(i)) begin
        case (selFld)
          FLD_FILT_ID: regRdData = REG_W'(filtArr[i]);
          FLD_MASK:    regRdData = REG_W'(maskArr[i]);
          FLD_CTRL:    regRdData = REG_W'({fullVec[i], enVec[i]});
          FLD_RX_ID:   regRdData = REG_W'(rxIdArr[i]);
          FLD_DLC:     regRdData = REG_W'(dlcArr[i]);
          FLD_DATA_LO: regRdData = dataArr[i][REG_W-1:0];
          FLD_DATA_HI: regRdData = dataArr[i][DATA_W-1:REG_W];
          default:     regRdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_rx_matcher.sv
module can_rx_matcher
  import can_rx_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  localparam int IDX_W  = $clog2(NUM_MBOX),
  localparam int ADDR_W = IDX_W + FLD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frmValid,
  input  logic                frmSelf,
  input  logic [ID_W-1:0]     frmId,
  input  logic [DLC_W-1:0]    frmDlc,
  input  logic [DATA_W-1:0]   frmData,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic [NUM_MBOX-1:0] mbFull,
  output logic                evStore,
  output logic                evOverrun,
  output logic                evNoMatch,
  output logic [IDX_W-1:0]    evIdx
);
  logic [ID_W-1:0]     pendId;
  logic [DLC_W-1:0]    pendDlc;
  logic [DATA_W-1:0]   pendData;
  logic [NUM_MBOX-1:0] hitVec;
  mbStrobeT            strobe;

  can_rx_match_ctrl #(.NUM_MBOX(NUM_MBOX)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .frmValid(frmValid), .frmSelf(frmSelf),
    .frmId(frmId), .frmDlc(frmDlc), .frmData(frmData),
    .hitVec(hitVec), .fullVec(mbFull),
    .pendId(pendId), .pendDlc(pendDlc), .pendData(pendData),
    .strobe(strobe),
    .evStore(evStore), .evOverrun(evOverrun), .evNoMatch(evNoMatch),
    .evIdx(evIdx)
  );

  can_rx_mbox_store #(.NUM_MBOX(NUM_MBOX)) u_store (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .pendId(pendId), .pendDlc(pendDlc), .pendData(pendData),
    .strobe(strobe),
    .hitVec(hitVec), .fullVec(mbFull)
  );
endmodule

// File: rtl/can_rx_matcher_chk.sv
module can_rx_matcher_chk #(
  parameter int NUM_MBOX = 8,
  localparam int IDX_W = $clog2(NUM_MBOX)
) (
  input logic                clk,
  input logic                rstN,
  input logic                frmValid,
  input logic                frmSelf,
  input logic [NUM_MBOX-1:0] mbFull,
  input logic                evStore,
  input logic                evOverrun,
  input logic                evNoMatch,
  input logic [IDX_W-1:0]    evIdx
);
  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evStore, evOverrun, evNoMatch}));

  // R8
  frame_gets_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmSelf) |-> ##2 (evStore || evOverrun || evNoMatch));

  // R6
  self_frame_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmSelf) |-> ##2 !(evStore || evOverrun || evNoMatch));

  // R4
  store_into_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    evStore |-> ((($past(mbFull) >> evIdx) & NUM_MBOX'(1)) == '0));

  // R8
  store_sets_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    evStore |-> mbFull[evIdx]);

  // R7
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    evOverrun |-> ((($past(mbFull) >> evIdx) & NUM_MBOX'(1)) != '0));
endmodule

bind can_rx_matcher can_rx_matcher_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (.*);

// File: tb/tb_can_rx_matcher.sv
module tb_can_rx_matcher;
  localparam int NMB = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0, frmSelf = 1'b0;
  logic [28:0] frmId = '0;
  logic [3:0]  frmDlc = '0;
  logic [63:0] frmData = '0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NMB-1:0] mbFull;
  logic        evStore, evOverrun, evNoMatch;
  logic [2:0]  evIdx;

  int checks = 0, errors = 0;

  // bench model of the mailbox state
  logic [28:0] mFilt [NMB];
  logic [28:0] mMask [NMB];
  logic [28:0] mRxId [NMB];
  logic [3:0]  mDlc  [NMB];
  logic [63:0] mData [NMB];
  logic        mEn   [NMB];
  logic        mFull [NMB];

  can_rx_matcher #(.NUM_MBOX(NMB)) dut (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmSelf(frmSelf),
    .frmId(frmId), .frmDlc(frmDlc), .frmData(frmData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .mbFull(mbFull), .evStore(evStore),
    .evOverrun(evOverrun), .evNoMatch(evNoMatch), .evIdx(evIdx)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NMB-1:0] modelFull();
    logic [NMB-1:0] v;
    for (int i = 0; i < NMB; i++) v[i] = mFull[i];
    return v;
  endfunction

  // kind: 0 no match, 1 store, 2 overrun
  function automatic void expectDest(input logic [28:0] id, output int kind, output int idx);
    int lastHit = -1;
    bit found = 0;
    idx = 0;
    for (int i = 0; i < NMB; i++) begin
      if (mEn[i] && (((id ^ mFilt[i]) & mMask[i]) == '0)) begin
        lastHit = i;
        if (!mFull[i] && !found) begin found = 1; idx = i; end
      end
    end
    if (found) kind = 1;
    else if (lastHit >= 0) begin kind = 2; idx = lastHit; end
    else kind = 0;
  endfunction

  function automatic void modelWrite(input int mb, input int fld, input logic [31:0] d);
    case (fld)
      0: mFilt[mb] = d[28:0];
      1: mMask[mb] = d[28:0];
      2: begin mEn[mb] = d[0]; mFull[mb] = d[1]; end
      default: ;
    endcase
  endfunction

  task automatic regWrite(input int mb, input int fld, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = {3'(mb), 3'(fld)}; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(mb, fld, d);
  endtask

  task automatic regRead(input int mb, input int fld, output logic [31:0] d);
    regAddr = {3'(mb), 3'(fld)};
    #1 d = regRdData;
  endtask

  task automatic setupMb(input int mb, input logic [28:0] id, input logic [28:0] mask, input bit en);
    regWrite(mb, 0, {3'b0, id});
    regWrite(mb, 1, {3'b0, mask});
    regWrite(mb, 2, {30'b0, 1'b0, en});
  endtask

  task automatic checkEvents(input string req, input int kind, input int idx);
    check(req, {61'b0, evStore, evOverrun, evNoMatch},
          {61'b0, kind == 1, kind == 2, kind == 0});
    check(req, {61'b0, evIdx}, 64'(idx));
  endtask

  task automatic checkStored(input string req, input int mb);
    logic [31:0] r;
    regRead(mb, 3, r); check(req, 64'(r), 64'(mRxId[mb]));
    regRead(mb, 4, r); check(req, 64'(r), 64'(mDlc[mb]));
    regRead(mb, 5, r); check(req, 64'(r), 64'(mData[mb][31:0]));
    regRead(mb, 6, r); check(req, 64'(r), 64'(mData[mb][63:32]));
  endtask

  function automatic void modelStore(input int mb, input logic [28:0] id,
                                     input logic [3:0] dlc, input logic [63:0] d);
    mFull[mb] = 1; mRxId[mb] = id; mDlc[mb] = dlc; mData[mb] = d;
  endfunction

  // strobe at edge k, results visible after edge k+1
  task automatic sendFrame(input string req, input logic [28:0] id, input bit self);
    int kind, idx;
    logic [3:0]  dlc = 4'($urandom_range(0, 8));
    logic [63:0] d = {$urandom, $urandom};
    @(negedge clk);
    frmValid = 1'b1; frmSelf = self; frmId = id; frmDlc = dlc; frmData = d;
    expectDest(id, kind, idx);
    @(negedge clk);
    frmValid = 1'b0; frmSelf = 1'b0;
    @(negedge clk);
    if (self) begin
      check(req, {61'b0, evStore, evOverrun, evNoMatch}, 64'd0);
    end else begin
      checkEvents(req, kind, idx);
      if (kind == 1) begin
        modelStore(idx, id, dlc, d);
        checkStored("R8", idx);
      end
    end
    check(req, 64'(mbFull), 64'(modelFull()));
  endtask

  initial begin
    logic [31:0] r;
    int kind, idx;
    logic [28:0] pool [4];
    void'($urandom(32'h5eed_c0de));
    pool[0] = 29'h0C20FF00; pool[1] = 29'h0C21FF00;
    pool[2] = 29'h0C22FF00; pool[3] = 29'h0C23FF00;
    for (int i = 0; i < NMB; i++) begin
      mFilt[i] = '0; mMask[i] = '0; mRxId[i] = '0; mDlc[i] = '0;
      mData[i] = '0; mEn[i] = 0; mFull[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state of every field
    for (int i = 0; i < NMB; i++) begin
      for (int f = 0; f < 7; f++) begin
        regRead(i, f, r);
        check("R10", 64'(r), 64'd0);
      end
    end
    check("R10", {60'b0, mbFull, evStore, evOverrun, evNoMatch, evIdx} , 64'd0);

    // shared filters plus a catch-all above them
    for (int i = 0; i < 3; i++) setupMb(i, 29'h0C20FF00, 29'h1FFFFF00, 1);
    for (int i = 3; i < 6; i++) setupMb(i, 29'h0C21FF00, 29'h1FFFFF00, 1);
    setupMb(6, 29'h0, 29'h0, 1);
    setupMb(7, 29'h0C23FF00, 29'h1FFFFFFF, 0);
    regRead(6, 1, r); check("R10", 64'(r), 64'd0);
    regRead(3, 0, r); check("R10", 64'(r), 64'h0C21FF00);

    sendFrame("R1", 29'h0C20FF12, 0);        // low byte ignored -> mb0
    sendFrame("R3", 29'h0C21FF34, 0);        // mb3 ahead of catch-all
    sendFrame("R5", 29'h0C21FF35, 0);        // mb4
    sendFrame("R5", 29'h0C21FF36, 0);        // mb5
    sendFrame("R4", 29'h0C21FF37, 0);        // group full -> catch-all mb6
    check("R4", 64'(mbFull), 64'h79);
    sendFrame("R7", 29'h0C21FF38, 0);        // overrun on mb6
    check("R7", {61'b0, evOverrun, evIdx}, {60'b0, 1'b1, 3'd6});
    checkStored("R7", 6);                    // mb6 still holds the previous frame

    // R2: catch-all disabled, mb7 disabled -> no match
    regWrite(6, 2, 32'h2);
    sendFrame("R2", 29'h0C23FF00, 0);
    check("R2", {61'b0, evNoMatch, evIdx}, {60'b0, 1'b1, 3'd0});

    // R6: own frame with empty matching mb1
    sendFrame("R6", 29'h0C20FF00, 1);

    // R9: release mb3 on the same edge as the strobe
    @(negedge clk);
    regWrEn = 1'b1; regAddr = {3'd3, 3'd2}; regWrData = 32'h1;
    frmValid = 1'b1; frmId = 29'h0C21FF99; frmDlc = 4'd2; frmData = 64'h1122;
    modelWrite(3, 2, 32'h1);
    expectDest(29'h0C21FF99, kind, idx);
    @(negedge clk);
    regWrEn = 1'b0; frmValid = 1'b0;
    @(negedge clk);
    check("R9", 64'(kind), 64'd1);
    checkEvents("R9", kind, idx);
    modelStore(idx, 29'h0C21FF99, 4'd2, 64'h1122);
    checkStored("R9", 3);

    // R11: host write on the edge that stores into mb1
    @(negedge clk);
    frmValid = 1'b1; frmId = 29'h0C20FF01; frmDlc = 4'd1; frmData = 64'h77;
    @(negedge clk);
    frmValid = 1'b0;
    regWrEn = 1'b1; regAddr = {3'd1, 3'd2}; regWrData = 32'h0;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R11", {61'b0, evStore, evIdx}, {60'b0, 1'b1, 3'd1});
    regRead(1, 2, r);
    check("R11", 64'(r), 64'h2);
    mEn[1] = 0; modelStore(1, 29'h0C20FF01, 4'd1, 64'h77);

    // R9: release clears the flag
    regWrite(0, 2, 32'h1);
    check("R9", 64'(mbFull[0]), 64'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      int mb = $urandom_range(0, NMB - 1);
      if (op == 0) begin
        int sel = $urandom_range(0, 3);
        logic [28:0] m = (sel == 0) ? 29'h1FFFFF00 : (sel == 1) ? 29'h1FFFFFFF :
                         (sel == 2) ? 29'h0 : 29'($urandom);
        setupMb(mb, pool[$urandom_range(0, 3)], m, $urandom_range(0, 3) != 0);
      end else if (op <= 3) begin
        regWrite(mb, 2, {30'b0, 1'b0, mEn[mb]});
      end else begin
        logic [28:0] id = pool[$urandom_range(0, 3)] | 29'($urandom_range(0, 255));
        if ($urandom_range(0, 15) == 0) id = 29'($urandom);
        expectDest(id, kind, idx);
        sendFrame(kind == 1 ? "R3" : "R7", id, $urandom_range(0, 7) == 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule